// File: doc/BRIEF.md
# Serial Mouse Packet Decoder

This block sits behind a UART receiver that is fed by a serial pointing device. Each received byte comes with a one-cycle valid strobe. The block groups the bytes into packets of three. The first byte of a packet carries the button states, the second carries horizontal motion and the third carries vertical motion.

For every complete packet the block presents the following on registered outputs, together with a one-cycle packet strobe:
- a signed horizontal delta;
- a sign-extended, negated vertical delta;
- a 3-bit button code, produced by reordering the raw button bits.

The line has no framing marker, so alignment is recovered from silence. When the gap between two byte strobes exceeds a parameterised number of clock cycles, the byte position is cleared and the next byte is taken as the start of a new packet.

Top module: `mouse_pkt_decoder`

## Requirements
- R1: After synchronous reset, `pkt_valid` is 0 and `dx`, `dy` and `buttons` are all 0.
- R2: The bytes accepted while `rx_valid` is high are counted in order 0, 1, 2. The strobe `pkt_valid` is high for exactly one cycle, in the cycle that follows the clock edge on which byte 2 is accepted. Position 0 is then expected next, and accepting byte 0 or byte 1 never raises `pkt_valid`.
- R3: The bits [2:0] of byte 0 are raw left (bit 0), right (bit 1) and middle (bit 2) buttons. `buttons` maps raw value to code as 0→0, 1→1, 2→4, 3→5, 4→2, 5→3, 6→6, 7→7. Bits [7:3] of byte 0 have no effect on any output.
- R4: `dx` equals byte 1 read as a two's-complement 8-bit value.
- R5: `dy` is a 9-bit two's-complement value equal to the negation of byte 2 read as a signed 8-bit value. A byte 2 of 0x80 gives +128 and a byte 2 of 0x7F gives -127.
- R6: Let the gap be the number of clock edges between two consecutive byte strobes. When the gap exceeds `TIMEOUT_CYCLES`, the later byte is taken as byte 0. When the gap equals `TIMEOUT_CYCLES`, the byte position continues normally.
- R7: Between packet strobes, `dx`, `dy` and `buttons` hold the values of the most recent packet.
- R8: `rx_byte` is ignored in any cycle where `rx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe marking a received byte |
| rx_byte | input | 8 | Received byte |
| pkt_valid | output | 1 | One-cycle pulse when a packet has been decoded |
| dx | output | 8 | Signed horizontal delta |
| dy | output | 9 | Signed vertical delta, negated and sign-extended |
| buttons | output | 3 | Remapped button code |

## Verification
The bench sweeps all 256 values through each byte position of a packet, so every remap entry is covered, as are both sign extremes of each delta. This catches the following faults:
- A remap that swaps the wrong pair of button bits.
- A status byte whose upper bits leak into the button code.
- A vertical delta that is only 8 bits wide, which would wrap +128 to -128.

The silence timeout is driven at gaps of exactly `TIMEOUT_CYCLES` and of one cycle more. An off-by-one comparison would either misframe the following packet or fail to resynchronise. Junk is driven on `rx_byte` while the strobe is low, and the outputs are watched between packets. A decoder that samples without the strobe, or that updates outside a packet strobe, would show altered values.

// File: rtl/mouse_pkg.sv
package mouse_pkg;
  localparam int PKT_BYTES = 3;
  localparam int IDX_W     = $clog2(PKT_BYTES);
  localparam int BYTE_W    = 8;
  localparam int DY_W      = BYTE_W + 1;

  typedef logic [IDX_W-1:0] idx_t;

  // raw {M,R,L} to output button code
  function automatic logic [2:0] remap_buttons(input logic [2:0] raw);
    logic [2:0] code;
    case (raw)
      3'd0: code = 3'd0;
      3'd1: code = 3'd1;
      3'd2: code = 3'd4;
      3'd3: code = 3'd5;
      3'd4: code = 3'd2;
      3'd5: code = 3'd3;
      3'd6: code = 3'd6;
      default: code = 3'd7;
    endcase
    return code;
  endfunction
endpackage

// File: rtl/mouse_silence_timer.sv
module mouse_silence_timer #(
  parameter int TIMEOUT_CYCLES = 400_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic byte_seen,
  output logic expired
);
  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYCLES);

  logic [CW-1:0] idle_q;

  // counts idle cycles since the last byte, saturating at LIMIT
  always_ff @(posedge clk) begin
    if (rst || byte_seen)
      idle_q <= '0;
    else if (idle_q != LIMIT)
      idle_q <= idle_q + CW'(1);
  end

  assign expired = (idle_q == LIMIT);

  p_idle_bounded_r6: assert property (@(posedge clk) disable iff (rst)
    idle_q <= LIMIT);

  p_byte_clears_r6: assert property (@(posedge clk) disable iff (rst)
    byte_seen |=> !expired || (TIMEOUT_CYCLES == 0));
endmodule

// File: rtl/mouse_byte_framer.sv
module mouse_byte_framer
  import mouse_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              expired,
  output logic              done,
  output logic [BYTE_W-1:0] status_b,
  output logic [BYTE_W-1:0] xdelta_b,
  output logic [BYTE_W-1:0] ydelta_b
);
  localparam idx_t LAST = idx_t'(PKT_BYTES - 1);

  idx_t              idx_q;
  idx_t              idx_eff;
  logic [BYTE_W-1:0] status_q, xdelta_q;

  // a long silence forces the arriving byte into position 0
  assign idx_eff = expired ? '0 : idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      status_q <= '0;
      xdelta_q <= '0;
    end else if (rx_valid) begin
      if (idx_eff == '0)      status_q <= rx_byte;
      if (idx_eff == idx_t'(1)) xdelta_q <= rx_byte;
      idx_q <= (idx_eff == LAST) ? '0 : idx_eff + idx_t'(1);
    end else if (expired) begin
      idx_q <= '0;
    end
  end

  assign done     = rx_valid && (idx_eff == LAST);
  assign status_b = status_q;
  assign xdelta_b = xdelta_q;
  assign ydelta_b = rx_byte;

  p_idx_range_r2: assert property (@(posedge clk) disable iff (rst)
    idx_q <= LAST);

  p_silence_resets_r6: assert property (@(posedge clk) disable iff (rst)
    (expired && !rx_valid) |=> (idx_q == '0));

  p_done_returns_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> (idx_q == '0));
endmodule

// File: rtl/mouse_pkt_format.sv
module mouse_pkt_format
  import mouse_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     done,
  input  logic [BYTE_W-1:0]        status_b,
  input  logic [BYTE_W-1:0]        xdelta_b,
  input  logic [BYTE_W-1:0]        ydelta_b,
  output logic                     pkt_valid,
  output logic signed [BYTE_W-1:0] dx,
  output logic signed [DY_W-1:0]   dy,
  output logic [2:0]               buttons
);
  logic signed [DY_W-1:0] y_ext;

  assign y_ext = $signed({ydelta_b[BYTE_W-1], ydelta_b});

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_valid <= 1'b0;
      dx        <= '0;
      dy        <= '0;
      buttons   <= '0;
    end else begin
      pkt_valid <= done;
      if (done) begin
        dx      <= $signed(xdelta_b);
        dy      <= -y_ext;
        buttons <= remap_buttons(status_b[2:0]);
      end
    end
  end

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |=> !pkt_valid);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> (dy <= 9'sd128) && (dy >= -9'sd127));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable({dx, dy, buttons}));
endmodule

// File: rtl/mouse_pkt_decoder.sv
module mouse_pkt_decoder
  import mouse_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 400_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              pkt_valid,
  output logic signed [7:0] dx,
  output logic signed [8:0] dy,
  output logic [2:0]        buttons
);
  logic              expired, done;
  logic [BYTE_W-1:0] status_b, xdelta_b, ydelta_b;

  mouse_silence_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) i_timer (
    .clk(clk), .rst(rst), .byte_seen(rx_valid), .expired(expired)
  );

  mouse_byte_framer i_framer (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .expired(expired), .done(done), .status_b(status_b),
    .xdelta_b(xdelta_b), .ydelta_b(ydelta_b)
  );

  mouse_pkt_format i_format (
    .clk(clk), .rst(rst), .done(done), .status_b(status_b),
    .xdelta_b(xdelta_b), .ydelta_b(ydelta_b), .pkt_valid(pkt_valid),
    .dx(dx), .dy(dy), .buttons(buttons)
  );

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> !pkt_valid && dx == '0 && dy == '0 && buttons == '0);
endmodule

// File: tb/test_mouse_pkt_decoder.sv
module test_mouse_pkt_decoder;
  localparam int TO = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic pkt_valid;
  logic signed [7:0] dx;
  logic signed [8:0] dy;
  logic [2:0] buttons;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  mouse_pkt_decoder #(.TIMEOUT_CYCLES(TO)) i_mouse_pkt_decoder (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .pkt_valid(pkt_valid), .dx(dx), .dy(dy), .buttons(buttons)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_btn(input logic [7:0] b);
    int l, r, m;
    l = b[0]; r = b[1]; m = b[2];
    return l + 2 * m + 4 * r;
  endfunction

  // idle for gap cycles with junk on rx_byte, then one strobe; returns at the negedge after it
  task automatic send(input logic [7:0] b, input int gap);
    for (int k = 0; k < gap; k++) begin
      rx_valid = 1'b0;
      rx_byte  = 8'(k * 37 + 11);
      @(negedge clk);
    end
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_byte  = ~b;
  endtask

  task automatic packet_check(input logic [7:0] s, input logic [7:0] x, input logic [7:0] y);
    send(s, 0);
    check("R2 no pulse after byte 0", int'(pkt_valid), 0);
    send(x, 0);
    check("R2 no pulse after byte 1", int'(pkt_valid), 0);
    send(y, 0);
    check("R2 pulse after byte 2", int'(pkt_valid), 1);
    check("R3 buttons", int'(buttons), exp_btn(s));
    check("R4 dx", int'(dx), int'($signed(x)));
    check("R5 dy", int'(dy), -int'($signed(y)));
    @(negedge clk);
    check("R2 single cycle pulse", int'(pkt_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 pkt_valid", int'(pkt_valid), 0);
    check("R1 dx", int'(dx), 0);
    check("R1 dy", int'(dy), 0);
    check("R1 buttons", int'(buttons), 0);

    // sweep all byte values through each position
    for (int i = 0; i < 256; i++)
      packet_check(8'(i), 8'(i), 8'(i ^ 8'h5A));

    // sign extremes
    packet_check(8'hF8, 8'h80, 8'h80);
    packet_check(8'h07, 8'h7F, 8'h7F);
    packet_check(8'h02, 8'hFF, 8'h01);

    // R7 and R8: outputs hold across idle cycles with junk on rx_byte
    packet_check(8'h05, 8'h33, 8'hC0);
    for (int k = 0; k < 6; k++) begin
      rx_byte = 8'(k * 91);
      @(negedge clk);
    end
    check("R7 dx held", int'(dx), 8'sh33);
    check("R7 dy held", int'(dy), 64);
    check("R8 buttons held", int'(buttons), 3);

    // R6: gap equal to timeout keeps framing
    send(8'h01, 0);
    send(8'h10, TO - 1);
    send(8'hF0, TO - 1);
    check("R6 gap equal no resync", int'(pkt_valid), 1);
    check("R6 gap equal dx", int'(dx), 16);
    check("R6 gap equal dy", int'(dy), 16);

    // R6: gap beyond timeout restarts at byte 0
    send(8'h06, 0);
    send(8'h44, 0);
    send(8'h04, TO);
    check("R6 resync no pulse on new byte 0", int'(pkt_valid), 0);
    send(8'h22, 0);
    check("R6 resync no pulse on new byte 1", int'(pkt_valid), 0);
    send(8'hFE, 0);
    check("R6 resync pulse", int'(pkt_valid), 1);
    check("R6 resync buttons", int'(buttons), 2);
    check("R6 resync dx", int'(dx), 34);
    check("R6 resync dy", int'(dy), 2);

    // long silence after a single byte
    send(8'h03, 0);
    repeat (TO + 5) @(negedge clk);
    packet_check(8'h03, 8'h01, 8'h02);

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule